// File: doc/BRIEF.md
# Codec Clock Bring-Up Sequencer

This block starts the crystal-referenced PLL clocking of an audio codec. It issues four control-register writes in a fixed order and waits a timed interval between them. A start pulse begins the run. The block releases the crystal input and powers the oscillator. It waits for the crystal to settle, then powers the PLL and waits for lock. It then enables the master clock output with the frequency-select field at its reset value. The last write changes that field, and it is issued only after a live frame clock (LRCK) has been seen coming back.

Each write goes to a downstream control-port master through a valid/ready handshake that carries one address and one data byte. All delays count whole milliseconds. The millisecond unit comes from a prescaler that is restarted at each accepted write, so every wait has an exact length in cycles. If the frame clock does not arrive within its timeout, the run stops with an error flag, and the frequency field is left unchanged.

Top module: `clk_bringup_seq`

## Requirements
- R1: After a synchronous reset, wr_valid, busy, done and error are all low and stay low until a start pulse.
- R2: A start pulse sampled while idle, done or in error makes busy and wr_valid high from the next cycle, and the first write is address 0x01, data 0x40 (bit 7 clear releases the crystal input pull-down, bit 6 set powers the oscillator). Starting again clears done and error.
- R3: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values. Exactly one sequence step is taken per accepted write (wr_valid and wr_ready high at the same edge), and wr_valid drops in the cycle after each acceptance.
- R4: The second write, address 0x01 data 0x60 (bit 5 powers the PLL), first shows wr_valid exactly OSC_SETTLE_MS*(CLK_HZ/1000)+1 cycles after the edge that accepted the first write.
- R5: The third write, address 0x04 data 0x4A (bit 3 enables the master clock output, frequency field bits 5:4 = 00), first shows wr_valid exactly PLL_LOCK_MS*(CLK_HZ/1000)+1 cycles after the edge that accepted the second write.
- R6: After the third write is accepted, rising edges of lrck_in pass through a two-flop synchroniser and are counted. Once LRCK_EDGES edges have been counted, the fourth write, address 0x04 data 0x6A (frequency field = 10), is issued. With fewer edges it is never issued. An edge that reaches the pin in the cycle after acceptance is counted 3 cycles later.
- R7: If LRCK_EDGES edges have not been counted by LRCK_TIMEOUT_MS*(CLK_HZ/1000) cycles after the third write was accepted, error rises one cycle later, busy falls, and no further write is issued.
- R8: done rises and busy falls at the edge that accepts the fourth write. done and error are never high together or with busy, and they hold until the next start.
- R9: A start pulse while busy is ignored: the sequence order and all wait lengths are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the bring-up sequence |
| lrck_in | input | 1 | Frame clock from the codec, asynchronous |
| wr_ready | input | 1 | Control-port master accepts the current write |
| wr_valid | output | 1 | A register write is offered |
| wr_addr | output | 8 | Register address of the offered write |
| wr_data | output | 8 | Register data of the offered write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished with the final write |
| error | output | 1 | Frame clock not detected in time |

## Verification
The sequence runs under every write-acceptance delay from zero to three cycles. Each delay is combined with frame-clock bursts of zero, two, three, four and six edges. The delays show that the wait lengths are counted from acceptance and not from the offer, and that the offered write stays held while stalled. The burst sizes separate the just-too-few and just-enough cases at the edge threshold: error and done are told apart, along with the exact cycle in which the final write appears. Some runs also inject a second start during the oscillator wait, and these must match the clean runs cycle for cycle.

// File: rtl/clk_bringup_pkg.sv
package clk_bringup_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_OSC,
        S_T_OSC,
        S_WR_PLL,
        S_T_LOCK,
        S_WR_MCK,
        S_LR_WAIT,
        S_WR_FS,
        S_DONE,
        S_ERR
    } seq_state_e;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } reg_wr_t;

    localparam logic [7:0] ADDR_PWR    = 8'h01;
    localparam logic [7:0] ADDR_CLK    = 8'h04;
    localparam logic [7:0] PWR_OSC_BIT = 8'h40;
    localparam logic [7:0] PWR_PLL_BIT = 8'h20;
    localparam logic [7:0] CLK_BASE    = 8'h4A;
    localparam logic [1:0] FS_DEFAULT  = 2'b00;
    localparam logic [1:0] FS_FINAL    = 2'b10;

    function automatic logic [7:0] clk_ctl(input logic [1:0] fs);
        return CLK_BASE | {2'b00, fs, 4'b0000};
    endfunction

    function automatic logic is_write(input seq_state_e s);
        return (s == S_WR_OSC) || (s == S_WR_PLL) ||
               (s == S_WR_MCK) || (s == S_WR_FS);
    endfunction

    function automatic reg_wr_t write_for(input seq_state_e s);
        reg_wr_t w;
        w = '0;
        case (s)
            S_WR_OSC: w = '{addr: ADDR_PWR, data: PWR_OSC_BIT};
            S_WR_PLL: w = '{addr: ADDR_PWR, data: PWR_OSC_BIT | PWR_PLL_BIT};
            S_WR_MCK: w = '{addr: ADDR_CLK, data: clk_ctl(FS_DEFAULT)};
            S_WR_FS:  w = '{addr: ADDR_CLK, data: clk_ctl(FS_FINAL)};
            default:  w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/cbs_ms_tick.sv
module cbs_ms_tick #(
    parameter int TICK_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int PRE_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    logic [PRE_W-1:0] pre;

    assign tick = (pre == PRE_W'(TICK_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre <= '0;
        end else if (tick) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/cbs_ms_timer.sv
module cbs_ms_timer #(
    parameter int MS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            tick,
    input  logic [MS_W-1:0] target,
    output logic            expired
);
    logic [MS_W-1:0] ms_cnt;

    assign expired = (ms_cnt >= target);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ms_cnt <= '0;
        end else if (tick && (ms_cnt != {MS_W{1'b1}})) begin
            ms_cnt <= ms_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cbs_lrck_detect.sv
module cbs_lrck_detect #(
    parameter int EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lrck_in,
    input  logic en,
    output logic present
);
    localparam int CNT_W = $clog2(EDGES + 1);

    logic [2:0]       sync_q;
    logic             rise;
    logic [CNT_W-1:0] cnt;

    assign rise    = sync_q[1] & ~sync_q[2];
    assign present = (cnt == CNT_W'(EDGES));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            cnt    <= '0;
        end else begin
            sync_q <= {sync_q[1:0], lrck_in};
            if (!en) begin
                cnt <= '0;
            end else if (rise && !present) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clk_bringup_seq.sv
module clk_bringup_seq
    import clk_bringup_pkg::*;
#(
    parameter int CLK_HZ          = 24_576_000,
    parameter int OSC_SETTLE_MS   = 20,
    parameter int PLL_LOCK_MS     = 40,
    parameter int LRCK_EDGES      = 4,
    parameter int LRCK_TIMEOUT_MS = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       lrck_in,
    input  logic       wr_ready,
    output logic       wr_valid,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       busy,
    output logic       done,
    output logic       error
);
    localparam int TICK_CYC = CLK_HZ / 1000;
    localparam int MS_MAX_A = (OSC_SETTLE_MS > PLL_LOCK_MS) ? OSC_SETTLE_MS : PLL_LOCK_MS;
    localparam int MS_MAX   = (MS_MAX_A > LRCK_TIMEOUT_MS) ? MS_MAX_A : LRCK_TIMEOUT_MS;
    localparam int MS_W     = $clog2(MS_MAX + 2);

    seq_state_e      state, state_nx;
    reg_wr_t         wr;
    logic            acc;
    logic            tick;
    logic            expired;
    logic            lr_present;
    logic [MS_W-1:0] target;

    assign wr       = write_for(state);
    assign wr_valid = is_write(state);
    assign wr_addr  = wr.addr;
    assign wr_data  = wr.data;
    assign acc      = wr_valid && wr_ready;
    assign busy     = (state != S_IDLE) && (state != S_DONE) && (state != S_ERR);
    assign done     = (state == S_DONE);
    assign error    = (state == S_ERR);

    always_comb begin
        case (state)
            S_T_OSC:  target = MS_W'(OSC_SETTLE_MS);
            S_T_LOCK: target = MS_W'(PLL_LOCK_MS);
            default:  target = MS_W'(LRCK_TIMEOUT_MS);
        endcase
    end

    cbs_ms_tick #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk (clk),
        .rst (rst),
        .clr (acc),
        .tick(tick)
    );

    cbs_ms_timer #(.MS_W(MS_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (acc),
        .tick   (tick),
        .target (target),
        .expired(expired)
    );

    cbs_lrck_detect #(.EDGES(LRCK_EDGES)) u_lrck (
        .clk    (clk),
        .rst    (rst),
        .lrck_in(lrck_in),
        .en     (state == S_LR_WAIT),
        .present(lr_present)
    );

    always_comb begin
        state_nx = state;
        case (state)
            S_IDLE, S_DONE, S_ERR: if (start) state_nx = S_WR_OSC;
            S_WR_OSC:  if (acc) state_nx = S_T_OSC;
            S_T_OSC:   if (expired) state_nx = S_WR_PLL;
            S_WR_PLL:  if (acc) state_nx = S_T_LOCK;
            S_T_LOCK:  if (expired) state_nx = S_WR_MCK;
            S_WR_MCK:  if (acc) state_nx = S_LR_WAIT;
            S_LR_WAIT: begin
                if (lr_present)   state_nx = S_WR_FS;
                else if (expired) state_nx = S_ERR;
            end
            S_WR_FS:   if (acc) state_nx = S_DONE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end
endmodule

// File: rtl/clk_bringup_chk.sv
module clk_bringup_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       wr_ready,
    input logic       wr_valid,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       busy,
    input logic       done,
    input logic       error
);
    a_r3_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    a_r3_drop_after_accept: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> !wr_valid);

    a_r2_valid_only_busy: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);

    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({busy, done, error}) <= 1);

    a_r8_done_after_final: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(wr_valid && wr_ready && wr_addr == 8'h04 && wr_data == 8'h6A));

    a_r7_error_without_write: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> $past(!wr_valid));
endmodule

bind clk_bringup_seq clk_bringup_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .wr_ready(wr_ready),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (busy),
    .done    (done),
    .error   (error)
);

// File: tb/sim_clk_bringup_seq.sv
`timescale 1ns/1ps
module sim_clk_bringup_seq;
    localparam int CLK_HZ  = 4000;
    localparam int OSC_MS  = 3;
    localparam int LOCK_MS = 2;
    localparam int EDGES   = 4;
    localparam int TO_MS   = 5;
    localparam int TCYC    = CLK_HZ / 1000;
    localparam int LR_HALF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       lrck_in = 1'b0;
    logic       wr_ready = 1'b0;
    logic       wr_valid;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       busy;
    logic       done;
    logic       error;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clk_bringup_seq #(
        .CLK_HZ(CLK_HZ), .OSC_SETTLE_MS(OSC_MS), .PLL_LOCK_MS(LOCK_MS),
        .LRCK_EDGES(EDGES), .LRCK_TIMEOUT_MS(TO_MS)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .lrck_in(lrck_in),
        .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done), .error(error)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_word(input int k);
        case (k)
            0: return 16'h0140;
            1: return 16'h0160;
            2: return 16'h044A;
            default: return 16'h046A;
        endcase
    endfunction

    function automatic int exp_gap(input int k);
        case (k)
            1: return OSC_MS * TCYC + 1;
            2: return LOCK_MS * TCYC + 1;
            default: return 3 + 2 * LR_HALF * (EDGES - 1) + 1;
        endcase
    endfunction

    task automatic run(input int delay, input int nedges, input bit inject);
        int  step = 0;
        int  wcount = 0;
        int  acc_edge [4];
        bit  prev_valid = 0;
        bit  prev_acc = 0;
        int  held = 0;
        bit  fin = 0;
        int  ph;
        for (int k = 0; k < 4; k++) acc_edge[k] = 0;
        @(negedge clk);
        start = 1'b1;
        for (int i = 0; i < 400 && !fin; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (i == 0) begin
                chk(busy, "R2 busy after start", busy, 1);
                chk(!done && !error, "R8 flags cleared by start", {done, error}, 0);
            end
            if (wr_valid && !prev_valid) begin
                if (step < 4) begin
                    chk({wr_addr, wr_data} == exp_word(step),
                        (step == 0) ? "R2 first write" : (step == 1) ? "R4 pll write" :
                        (step == 2) ? "R5 mclk write" : "R6 final write",
                        {wr_addr, wr_data}, exp_word(step));
                    if (step == 0) chk(i == 0, "R2 write in cycle after start", i, 0);
                    if (step >= 1)
                        chk(cyc - acc_edge[step-1] == exp_gap(step),
                            (step == 1) ? (inject ? "R9 osc wait with extra start" : "R4 osc wait") :
                            (step == 2) ? "R5 lock wait" : "R6 lrck detect latency",
                            cyc - acc_edge[step-1], exp_gap(step));
                    if (step == 3)
                        chk(nedges >= EDGES, "R6 final write needs edges", nedges, EDGES);
                end else begin
                    chk(0, "R3 extra write", step, 4);
                end
            end
            if (wr_valid && prev_valid && !prev_acc)
                chk({wr_addr, wr_data} == held, "R3 held while stalled", {wr_addr, wr_data}, held);
            if (prev_acc)
                chk(!wr_valid, "R3 valid drops after accept", wr_valid, 0);
            held = {wr_addr, wr_data};
            if (wr_valid) begin
                wr_ready = (wcount >= delay);
                if (wr_ready) begin
                    if (step < 4) acc_edge[step] = cyc + 1;
                    step++;
                    wcount = 0;
                end else begin
                    wcount++;
                end
            end else begin
                wr_ready = 1'b0;
            end
            prev_acc = wr_valid && wr_ready;
            prev_valid = wr_valid;
            if (inject && step == 1 && cyc == acc_edge[0] + 3) start = 1'b1;
            if (step >= 3 && cyc >= acc_edge[2]) begin
                ph = cyc - acc_edge[2];
                lrck_in = ((ph % (2 * LR_HALF)) < LR_HALF) && (ph / (2 * LR_HALF) < nedges);
            end else begin
                lrck_in = 1'b0;
            end
            if (done || error) begin
                fin = 1;
                if (nedges >= EDGES) begin
                    chk(done && step == 4, "R8 done after final write", step, 4);
                    chk(cyc == acc_edge[3], "R8 done timing", cyc, acc_edge[3]);
                end else begin
                    chk(error && step == 3, "R7 error without final write", step, 3);
                    chk(cyc == acc_edge[2] + TO_MS * TCYC + 1, "R7 timeout timing",
                        cyc, acc_edge[2] + TO_MS * TCYC + 1);
                end
                chk(!busy, "R8 busy low at end", busy, 0);
            end
        end
        chk(fin, "R3 sequence finished", fin, 1);
        wr_ready = 1'b0;
        lrck_in = 1'b0;
        repeat (5) @(negedge clk);
        chk(!wr_valid && (done == (nedges >= EDGES)) && (error == (nedges < EDGES)),
            "R8 end flags held", {wr_valid, done, error}, (nedges >= EDGES) ? 2 : 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!wr_valid && !busy && !done && !error, "R1 idle after reset",
                {wr_valid, busy, done, error}, 0);
        end
        for (int d = 0; d < 4; d++) begin
            run(d, 0, 1'b0);
            run(d, 2, 1'b0);
            run(d, 3, d == 1);
            run(d, 4, d == 2);
            run(d, 6, 1'b0);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule